// File: doc/BRIEF.md
# Framebuffer scanout cache reader

This block copies a small 16-bit-per-pixel frame out of external memory into an on-chip line store. It then serves pixel lookups from the display timing logic. The fetch runs in an AXI clock domain. A one-cycle start pulse, sampled in the video clock domain and accepted only while the fill enable is high, launches one fill. The block reads the frame one 256-bit beat at a time. Each beat is a single-beat read burst, and the block waits for that beat's data before it issues the next address.

On the video side, a byte address selects one pixel. The block returns it two video clock edges later as 8-bit red, green and blue, widened from the stored 5-bit fields. Addresses past the end of the frame return black. Every lookup also returns black while no complete frame is held. A level flag reports that the store holds a complete frame. Two counters report the beats received in the last fill and how many of those beats came back with an error response.

Top module: `fb_scan_cache`

## Requirements
- R1: After reset, cache_valid is 0, both counters are 0, m_arvalid is 0 and every lookup returns black (0,0,0).
- R2: While fill_en is low, a frame_start pulse produces no AXI read address request.
- R3: A fill issues one read per beat, in order, for beat index i from 0 to 255. Each read has m_arlen=0, m_arsize=5 (32 bytes) and m_arburst=01 (incrementing), with m_araddr = BASE_ADDR + 32*i. m_arvalid stays low from the address handshake until the beat carrying m_rlast is accepted, and m_rready is high throughout the fill.
- R4: A completed fill raises cache_valid, leaves beat_count at 256, and leaves err_count at 0 when every response is 00.
- R5: The pixel index is the byte address shifted right by one. The pixel is lane (index mod 16), bits [16k+15:16k], of beat (index / 16). Red comes from bits [4:0], green from [9:5] and blue from [14:10]; bit 15 has no effect. Each 5-bit channel c becomes {c, c[4:2]}.
- R6: The colour for an address appears two video clock edges after the address is applied. After one edge, the output still shows the previous address.
- R7: Any address of 0x2000 or above returns black.
- R8: Starting a new fill drops cache_valid. Lookups return black until all 256 beats of the new fill are stored and cache_valid rises again through a two-flop synchronizer.
- R9: A beat whose m_rresp is not 00 adds 1 to err_count. That beat is still stored in the cache and counted in beat_count.
- R10: A frame_start pulse that arrives while a fill is running is ignored, so each fill issues exactly 256 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | AXI domain clock |
| a_rst_n | input | 1 | AXI domain synchronous active-low reset |
| vclk | input | 1 | Video domain clock |
| v_rst_n | input | 1 | Video domain synchronous active-low reset |
| fill_en | input | 1 | Permits fills; quasi-static, video domain |
| frame_start | input | 1 | One-cycle fill request, video domain |
| rd_addr | input | 32 | Byte address of the pixel to look up |
| pix_r | output | 8 | Red, two edges after rd_addr |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |
| cache_valid | output | 1 | Complete frame held, video domain |
| beat_count | output | 32 | Beats received in the current or last fill, AXI domain |
| err_count | output | 32 | Beats with a non-OKAY response, AXI domain |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Burst length minus one (always 0) |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_arvalid | output | 1 | Address valid |
| m_arready | input | 1 | Address ready |
| m_rdata | input | 256 | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench builds the block with a 64x64 frame, 256-bit beats and 32-bit counters, which matches the stated frame geometry. It sets BASE_ADDR to 0x10000 so that the base-plus-offset address sum is checked against a nonzero base. With this geometry the final in-range address 0x1FFE and the first black address 0x2000 both fall inside the test. It also reaches lane 15 of a beat and the lane-0 boundary into the next beat. The memory model gives each fill different pixel data and can return an error response on a chosen beat. A refill therefore shows that cache_valid drops and that error beats are stored.

// File: rtl/fbsc_pkg.sv
// Shared types and helpers for the framebuffer scanout cache reader.
// Assumes 16-bit pixels holding three 5-bit colour fields.
package fbsc_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ADDR = 2'd1,
        FS_DATA = 2'd2
    } fill_state_t;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam int         PIX_BITS   = 16;

    // Widen a 5-bit colour field to 8 bits by repeating its top bits.
    function automatic logic [7:0] widen5(input logic [4:0] c);
        return {c, c[4:2]};
    endfunction

endpackage

// File: rtl/fbsc_bit_sync.sv
// Multi-flop level synchronizer into the destination clock domain.
// Assumes the input is a level that stays stable for several destination cycles.
module fbsc_bit_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fbsc_pulse_sync.sv
// Moves a single-cycle pulse across clock domains with a toggle flop,
// a synchronizer chain and an edge detector.
// Assumes source pulses are spaced further apart than the synchronizer delay.
module fbsc_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic            tgl;
    logic [STAGES:0] chain;

    // Flip the toggle once per source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     tgl <= 1'b0;
        else if (src_pulse) tgl <= ~tgl;
    end

    // Synchronize the toggle and keep one extra stage for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) chain <= '0;
        else            chain <= {chain[STAGES-1:0], tgl};
    end

    assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

    AST_PULSE_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse); // R10
endmodule

// File: rtl/fbsc_line_store.sv
// Two-clock simple dual-port store: write port in the fill domain, registered
// read port in the video domain. Contents are not reset.
// Assumes no read of a word during the same period it is being written.
module fbsc_line_store #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one beat per write strobe.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered synchronous read.
    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/fbsc_fill_ctrl.sv
// AXI4 read master that fetches the frame beat by beat into the line store.
// Issues one single-beat burst at a time, keeps the receive and error
// counters, and raises done after the last beat is written.
// Assumes start is a one-cycle pulse that is already in the AXI clock domain.
module fbsc_fill_ctrl
    import fbsc_pkg::*;
#(
    parameter int          NUM_BEATS = 256,
    parameter int          DATA_W    = 256,
    parameter int          ADDR_W    = 32,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0,
    localparam int IDX_W  = $clog2(NUM_BEATS),
    localparam int OFFS_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    output logic              arvalid,
    input  logic              arready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    input  logic              rvalid,
    output logic              rready,
    output logic              we,
    output logic [IDX_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  beat_cnt,
    output logic [CNT_W-1:0]  err_cnt,
    output logic              done
);
    fill_state_t          state;
    logic [IDX_W-1:0]     idx;

    // Sequence address and data phases, and keep the counters and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            idx      <= '0;
            beat_cnt <= '0;
            err_cnt  <= '0;
            done     <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: if (start && en) begin
                    state    <= FS_ADDR;
                    idx      <= '0;
                    beat_cnt <= '0;
                    err_cnt  <= '0;
                    done     <= 1'b0;
                end
                FS_ADDR: if (arready) state <= FS_DATA;
                FS_DATA: if (rvalid) begin
                    beat_cnt <= beat_cnt + 1'b1;
                    if (rresp != RESP_OKAY) err_cnt <= err_cnt + 1'b1;
                    if (rlast) begin
                        if (idx == IDX_W'(NUM_BEATS - 1)) begin
                            done  <= 1'b1;
                            state <= FS_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= FS_ADDR;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign arvalid = (state == FS_ADDR);
    assign rready  = (state != FS_IDLE);
    assign araddr  = ADDR_W'(BASE_ADDR) + (ADDR_W'(idx) << OFFS_W);
    assign arlen   = 8'd0;
    assign arsize  = 3'(OFFS_W);
    assign arburst = BURST_INCR;
    assign we      = (state == FS_DATA) && rvalid;
    assign waddr   = idx;
    assign wdata   = rdata;

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr))); // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> !arvalid); // R3
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        beat_cnt <= CNT_W'(NUM_BEATS)); // R4
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (beat_cnt == CNT_W'(NUM_BEATS))); // R4
    AST_ERR_LE_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= beat_cnt); // R9
endmodule

// File: rtl/fb_scan_cache.sv
// Framebuffer scanout cache reader (top).
// Video domain: gates frame_start with fill_en, forwards it to the AXI domain,
// and serves pixel lookups through a two-stage pipeline (store read, then
// decode). AXI domain: runs the fill controller.
// Assumes fill_en is quasi-static and that rd_addr is a byte address.
module fb_scan_cache
    import fbsc_pkg::*;
#(
    parameter int          FRAME_W   = 64,
    parameter int          FRAME_H   = 64,
    parameter int          DATA_W    = 256,
    parameter int          ADDR_W    = 32,
    parameter int          CNT_W     = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0
) (
    input  logic              aclk,
    input  logic              a_rst_n,
    input  logic              vclk,
    input  logic              v_rst_n,
    input  logic              fill_en,
    input  logic              frame_start,
    input  logic [31:0]       rd_addr,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b,
    output logic              cache_valid,
    output logic [CNT_W-1:0]  beat_count,
    output logic [CNT_W-1:0]  err_count,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    input  logic              m_rvalid,
    output logic              m_rready
);
    localparam int PIX_PER_BEAT = DATA_W / PIX_BITS;
    localparam int NUM_PIX      = FRAME_W * FRAME_H;
    localparam int NUM_BEATS    = NUM_PIX / PIX_PER_BEAT;
    localparam int IDX_W        = $clog2(NUM_BEATS);
    localparam int LANE_W       = $clog2(PIX_PER_BEAT);
    localparam int BYTE_LIMIT   = NUM_PIX * 2;

    logic              start_v, start_a, en_a, done_a;
    logic              st_we;
    logic [IDX_W-1:0]  st_waddr;
    logic [DATA_W-1:0] st_wdata, st_rdata;
    logic [LANE_W-1:0] lane_q;
    logic              hit_q;
    logic [14:0]       px;

    assign start_v = frame_start && fill_en;

    fbsc_pulse_sync #(.STAGES(2)) u_start_sync (
        .src_clk(vclk), .src_rst_n(v_rst_n), .src_pulse(start_v),
        .dst_clk(aclk), .dst_rst_n(a_rst_n), .dst_pulse(start_a)
    );

    fbsc_bit_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_en_sync (
        .clk(aclk), .rst_n(a_rst_n), .d(fill_en), .q(en_a)
    );

    fbsc_fill_ctrl #(
        .NUM_BEATS(NUM_BEATS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR)
    ) u_fill (
        .clk(aclk), .rst_n(a_rst_n), .start(start_a), .en(en_a),
        .araddr(m_araddr), .arlen(m_arlen), .arsize(m_arsize),
        .arburst(m_arburst), .arvalid(m_arvalid), .arready(m_arready),
        .rdata(m_rdata), .rresp(m_rresp), .rlast(m_rlast),
        .rvalid(m_rvalid), .rready(m_rready),
        .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .beat_cnt(beat_count), .err_cnt(err_count), .done(done_a)
    );

    fbsc_line_store #(.DEPTH(NUM_BEATS), .WIDTH(DATA_W)) u_store (
        .wclk(aclk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .rclk(vclk), .raddr(rd_addr[IDX_W+LANE_W:LANE_W+1]), .rdata(st_rdata)
    );

    fbsc_bit_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_valid_sync (
        .clk(vclk), .rst_n(v_rst_n), .d(done_a), .q(cache_valid)
    );

    // Stage 1: latch the lane and whether the lookup may return real data.
    always_ff @(posedge vclk) begin
        if (!v_rst_n) begin
            lane_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            lane_q <= rd_addr[LANE_W:1];
            hit_q  <= cache_valid && (rd_addr < 32'(BYTE_LIMIT));
        end
    end

    assign px = st_rdata[lane_q*PIX_BITS +: 15];

    // Stage 2: widen the colour fields, or output black.
    always_ff @(posedge vclk) begin
        if (!v_rst_n || !hit_q) begin
            pix_r <= 8'd0;
            pix_g <= 8'd0;
            pix_b <= 8'd0;
        end else begin
            pix_r <= widen5(px[4:0]);
            pix_g <= widen5(px[9:5]);
            pix_b <= widen5(px[14:10]);
        end
    end

    AST_INVALID_BLACK: assert property (@(posedge vclk) disable iff (!v_rst_n)
        !cache_valid |=> ##1 (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0)); // R8
    AST_RANGE_BLACK: assert property (@(posedge vclk) disable iff (!v_rst_n)
        (rd_addr >= 32'(BYTE_LIMIT)) |=> ##1 (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0)); // R7
    AST_NO_FETCH_DISABLED: assert property (@(posedge aclk) disable iff (!a_rst_n)
        (!en_a && !m_arvalid) |=> !m_arvalid); // R2
endmodule

// File: tb/fb_scan_cache_test.sv
`timescale 1ns/1ps
module fb_scan_cache_test;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int NB = 256;

    logic aclk = 1'b0, vclk = 1'b0;
    always #4  aclk = ~aclk;
    always #10 vclk = ~vclk;

    logic a_rst_n, v_rst_n, fill_en, frame_start;
    logic [31:0] rd_addr;
    logic [7:0] pix_r, pix_g, pix_b;
    logic cache_valid;
    logic [31:0] beat_count, err_count, m_araddr;
    logic [7:0] m_arlen; logic [2:0] m_arsize; logic [1:0] m_arburst;
    logic m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;
    logic [255:0] m_rdata; logic [1:0] m_rresp;

    fb_scan_cache #(.FRAME_W(64), .FRAME_H(64), .DATA_W(256), .ADDR_W(32),
                    .CNT_W(32), .BASE_ADDR(BASE)) uut (
        .aclk(aclk), .a_rst_n(a_rst_n), .vclk(vclk), .v_rst_n(v_rst_n),
        .fill_en(fill_en), .frame_start(frame_start), .rd_addr(rd_addr),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .cache_valid(cache_valid),
        .beat_count(beat_count), .err_count(err_count),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] seed = 16'h0;
    bit inj_err = 0;
    int err_beat = 0;

    function automatic logic [15:0] pv(input int idx, input logic [15:0] s);
        logic [31:0] t;
        t = idx * 32'h9E37 + {16'h0, s};
        return t[15:0];
    endfunction

    function automatic logic [255:0] beat_word(input int b, input logic [15:0] s);
        logic [255:0] w;
        for (int k = 0; k < 16; k++) w[16*k +: 16] = pv(b*16 + k, s);
        return w;
    endfunction

    function automatic logic [23:0] exp_px(input logic [31:0] a, input logic [15:0] s);
        logic [15:0] p; logic [4:0] r5, g5, b5;
        if (a >= 32'h2000) return 24'h0;
        p = pv(int'(a >> 1), s);
        r5 = p[4:0]; g5 = p[9:5]; b5 = p[14:10];
        return {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2]};
    endfunction

    // AXI read memory model with protocol monitors.
    int ar_count = 0, ar_bad = 0, overlap = 0, rready_low = 0, ar_dis = 0;
    int sst = 0, sdly = 0, sbeat = 0;
    always @(posedge aclk) begin
        if (!a_rst_n) begin
            sst <= 0; m_arready <= 1'b0; m_rvalid <= 1'b0; m_rlast <= 1'b0;
            m_rdata <= '0; m_rresp <= 2'b00;
        end else begin
            if (!fill_en && m_arvalid) ar_dis <= ar_dis + 1;
            case (sst)
                0: if (m_arvalid && m_arready) begin
                       m_arready <= 1'b0;
                       if (m_araddr != BASE + 32'(32 * (ar_count % NB)) ||
                           m_arlen != 8'd0 || m_arsize != 3'd5 || m_arburst != 2'b01)
                           ar_bad <= ar_bad + 1;
                       sbeat <= int'((m_araddr - BASE) >> 5);
                       ar_count <= ar_count + 1;
                       sdly <= 2; sst <= 1;
                   end else if (m_arvalid) m_arready <= 1'b1;
                1: begin
                       if (m_arvalid) overlap <= overlap + 1;
                       if (!m_rready) rready_low <= rready_low + 1;
                       if (sdly == 0) begin
                           m_rdata <= beat_word(sbeat, seed);
                           m_rresp <= (inj_err && sbeat == err_beat) ? 2'b10 : 2'b00;
                           m_rvalid <= 1'b1; m_rlast <= 1'b1; sst <= 2;
                       end else sdly <= sdly - 1;
                   end
                default: begin
                       if (m_arvalid) overlap <= overlap + 1;
                       if (m_rready) begin m_rvalid <= 1'b0; m_rlast <= 1'b0; sst <= 0; end
                   end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic read_px(input logic [31:0] a, output logic [23:0] got);
        @(negedge vclk) rd_addr = a;
        @(posedge vclk); @(posedge vclk); #1;
        got = {pix_r, pix_g, pix_b};
    endtask

    task automatic pulse_start();
        @(negedge vclk) frame_start = 1'b1;
        @(negedge vclk) frame_start = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        logic [23:0] g;
        chk("R1 cache_valid", {31'h0, cache_valid}, 32'd0);
        chk("R1 beat_count", beat_count, 32'd0);
        chk("R1 err_count", err_count, 32'd0);
        chk("R1 arvalid", {31'h0, m_arvalid}, 32'd0);
        read_px(32'h0, g);
        chk("R1 black after reset", {8'h0, g}, 32'h0);
    endtask

    task automatic t_disabled();
        fill_en = 1'b0;
        pulse_start();
        repeat (80) @(posedge aclk);
        #1;
        chk("R2 no AR when disabled", ar_count, 32'd0);
        chk("R2 still invalid", {31'h0, cache_valid}, 32'd0);
    endtask

    task automatic t_fill(input logic [15:0] s, input bit inj, input int eb, input int exp_err);
        int base, to;
        logic [23:0] g;
        seed = s; inj_err = inj; err_beat = eb;
        base = ar_count;
        fill_en = 1'b1;
        repeat (4) @(posedge vclk);
        pulse_start();
        repeat (20) @(posedge vclk);
        #1;
        chk("R8 valid low during fill", {31'h0, cache_valid}, 32'd0);
        read_px(32'h40, g);
        chk("R8 black during fill", {8'h0, g}, 32'h0);
        pulse_start();  // R10: ignored mid-fill
        to = 0;
        while (!cache_valid && to < 20000) begin @(posedge vclk); to++; end
        repeat (40) @(posedge aclk);
        #1;
        chk("R4 cache_valid set", {31'h0, cache_valid}, 32'd1);
        chk("R4 beat_count", beat_count, 32'd256);
        chk("R9 err_count", err_count, 32'(exp_err));
        chk("R10 reads per fill", 32'(ar_count - base), 32'd256);
        chk("R3 AR fields and address", ar_bad, 32'd0);
        chk("R3 no AR before rlast accepted", overlap, 32'd0);
        chk("R3 rready held", rready_low, 32'd0);
        chk("R2 no AR while enable low", ar_dis, 32'd0);
    endtask

    task automatic t_pixels(input string tag);
        logic [23:0] g;
        logic [31:0] list [8] = '{32'h0, 32'h2, 32'h1E, 32'h20, 32'h80,
                                 32'h0A6, 32'h1000, 32'h1FFE};
        foreach (list[i]) begin
            read_px(list[i], g);
            chk(tag, {8'h0, g}, {8'h0, exp_px(list[i], seed)});
        end
        for (int a = 0; a < 32'h2000; a += 32'h13A) begin
            read_px(32'(a) & 32'hFFFE, g);
            chk(tag, {8'h0, g}, {8'h0, exp_px(32'(a) & 32'hFFFE, seed)});
        end
    endtask

    task automatic t_range();
        logic [23:0] g;
        read_px(32'h2000, g); chk("R7 0x2000 black", {8'h0, g}, 32'h0);
        read_px(32'h2002, g); chk("R7 0x2002 black", {8'h0, g}, 32'h0);
        read_px(32'hFFFF_FFFE, g); chk("R7 top black", {8'h0, g}, 32'h0);
    endtask

    task automatic t_latency();
        logic [23:0] g;
        read_px(32'h0042, g);
        @(negedge vclk) rd_addr = 32'h1F20;
        @(posedge vclk); #1;
        chk("R6 one edge shows old", {8'h0, pix_r, pix_g, pix_b}, {8'h0, exp_px(32'h0042, seed)});
        @(posedge vclk); #1;
        chk("R6 two edges shows new", {8'h0, pix_r, pix_g, pix_b}, {8'h0, exp_px(32'h1F20, seed)});
    endtask

    initial begin
        fill_en = 1'b0; frame_start = 1'b0; rd_addr = 32'h0;
        a_rst_n = 1'b0; v_rst_n = 1'b0;
        repeat (6) @(posedge vclk);
        a_rst_n = 1'b1; v_rst_n = 1'b1;
        repeat (4) @(posedge vclk);
        t_reset();
        t_disabled();
        t_fill(16'h0000, 1'b0, 0, 0);
        t_pixels("R5 decode fill 1");
        t_range();
        t_latency();
        t_fill(16'hB5A3, 1'b1, 5, 1);   // R9: error beat 5 still stored
        t_pixels("R9 R5 decode after refill");
        finished = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge vclk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
            report();
        end
    end
endmodule